// File: doc/BRIEF.md
# Loopback UART Register File

This block presents the eight byte-wide registers of a 16550-style serial controller with no serial line behind them. Bytes that software writes to the transmit data offset go into a small circular FIFO, and reads of the receive data offset return them in the order they were written. The line status, modem status and interrupt identification registers are computed from the FIFO fill level, a sticky overrun flag and the modem control bits. This lets a driver for a 16550-class port be brought up against the register file alone.

Software reaches the block through a 3-bit offset, a write strobe with write data, and a read strobe. Read data is registered and appears on the cycle after the strobe. The interrupt output is a one-cycle pulse, raised on the events listed below. Setting LCR bit 7 (the divisor latch bit) turns offsets 0 and 1 into the two bytes of a 16-bit divisor. The divisor is only stored and read back.

Top module: `loopuart_regs`

## Requirements
- R1: After reset the FIFO is empty, enabled and 16 entries deep, with a trigger level of 1. All registers and the divisor are zero. IIR then reads 0xC1, LSR reads 0x60 and MSR reads 0xB3.
- R2: Setting LCR bit 7 makes offset 0 access divisor bits 7:0 and offset 1 access divisor bits 15:8. Every LCR write with bit 7 set clears the divisor. Divisor writes OR the byte into the addressed half.
- R3: A write to offset 0 with LCR bit 7 clear appends the byte if the count is below the maximum size, and clears overrun. Otherwise the byte is dropped and overrun is set. The count never exceeds 16.
- R4: Reads of offset 0 with LCR bit 7 clear return bytes oldest first, across the 16-entry wrap. A read of an empty FIFO returns 0 and changes nothing.
- R5: An FCR write (offset 2) sets the FIFO enable from bit 0. A clear enable makes the maximum size 1 and the trigger level 1. Bits 7:6 select trigger level 1, 4, 8 or 14 (codes 0 to 3). Bit 1 or bit 2 empties the FIFO.
- R6: IER (offset 1, LCR bit 7 clear) reads back only its low four bits. The bits are: bit 0 receive data, bit 1 transmit empty, bit 2 line status, bit 3 modem status.
- R7: IIR (offset 2 read) reports only the highest pending cause, ORed with 0xC0. The codes, highest priority first, are 0xC6 (overrun with IER bit 2), 0xC4 (count at or above trigger with IER bit 0), 0xC2 (FIFO empty with IER bit 1) and 0xC0 (MCR bit 0 or 1 set with IER bit 3). With no cause pending it reads 0xC1.
- R8: LSR (offset 5) has bit 0 set when the FIFO is not empty and bit 1 set when overrun is set. Bits 5 and 6 are set when the FIFO is empty.
- R9: MSR (offset 6) always has bits 7, 5 and 1 set. Bits 4 and 0 are also set unless MCR bit 5 is set and the count has reached the maximum size.
- R10: irq pulses in four cases: a push that brings the count to the trigger level while IER bit 0 is set; a dropped byte while IER bit 2 is set; a read that empties the FIFO while IER bit 1 is set; an IER write with bit 1 set while the FIFO is empty.
- R11: irq pulses on an MCR write (offset 4) with bit 3, 1 or 0 set while IER bit 3 is set.
- R12: Writes to offsets 5 and 6 have no effect. SCR (offset 7), LCR (offset 3) and MCR read back what was written.
- R13: A read and a write in the same cycle at offset 0 pop the oldest byte and append the new one. The read returns the value from before the cycle. The push-accept check uses the count from before the cycle.
- R14: Read data appears the cycle after rd_en and holds until the next read. irq lasts exactly one cycle per triggering access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 3 | Register offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Because read and write share one offset, a read and a write of offset 0 in the same cycle both pop and push the FIFO. The count, the accept decision and the interrupt conditions must then all be taken from the pre-cycle state. The bench provokes this with a directed case on a partly filled FIFO and a full one, and again in the random phase. In the random phase both strobes are frequently raised together. The bench model applies the read to the old state before the write, so every returned byte and every irq pulse is compared against that order.

// File: rtl/loopuart_pkg.sv
package loopuart_pkg;
  localparam logic [2:0] OFS_DATA = 3'd0;
  localparam logic [2:0] OFS_IER  = 3'd1;
  localparam logic [2:0] OFS_FCR  = 3'd2;
  localparam logic [2:0] OFS_LCR  = 3'd3;
  localparam logic [2:0] OFS_MCR  = 3'd4;
  localparam logic [2:0] OFS_LSR  = 3'd5;
  localparam logic [2:0] OFS_MSR  = 3'd6;
  localparam logic [2:0] OFS_SCR  = 3'd7;

  // interrupt enable bit positions
  localparam int EN_RXDATA = 0;
  localparam int EN_TXEMPTY = 1;
  localparam int EN_LINE = 2;
  localparam int EN_MODEM = 3;

  function automatic logic [7:0] trig_decode(input logic [1:0] code);
    case (code)
      2'd0: return 8'd1;
      2'd1: return 8'd4;
      2'd2: return 8'd8;
      default: return 8'd14;
    endcase
  endfunction
endpackage

// File: rtl/loopuart_fifo.sv
module loopuart_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;

  // storage has no reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (push) mem[head_q] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) head_q <= head_q + PTR_W'(1);
      if (pop)  tail_q <= tail_q + PTR_W'(1);
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign rdata = mem[tail_q];
  assign count = cnt_q;
endmodule

// File: rtl/loopuart_status.sv
module loopuart_status #(
  parameter int CNT_W = 5
) (
  input  logic [3:0]       ier,
  input  logic [7:0]       mcr,
  input  logic             overrun,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] trig,
  input  logic [CNT_W-1:0] fmax,
  output logic [7:0]       iir,
  output logic [7:0]       lsr,
  output logic [7:0]       msr
);
  import loopuart_pkg::*;
  logic empty;
  assign empty = (count == '0);

  always_comb begin
    if (ier[EN_LINE] && overrun)                iir = 8'hC6;
    else if (ier[EN_RXDATA] && count >= trig)   iir = 8'hC4;
    else if (ier[EN_TXEMPTY] && empty)          iir = 8'hC2;
    else if (ier[EN_MODEM] && (mcr[1] | mcr[0])) iir = 8'hC0;
    else                                        iir = 8'hC1;
  end

  always_comb begin
    lsr = 8'h00;
    lsr[0] = !empty;
    lsr[1] = overrun;
    lsr[5] = empty;
    lsr[6] = empty;
  end

  always_comb begin
    msr = 8'hA2;
    if (!(mcr[5] && count >= fmax)) msr = msr | 8'h11;
  end
endmodule

// File: rtl/loopuart_regs.sv
module loopuart_regs #(
  parameter int DEPTH = 16,
  localparam int DATA_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  import loopuart_pkg::*;

  logic [7:0] ier_q, lcr_q, mcr_q, scr_q;
  logic [15:0] div_q;
  logic fifo_en_q, overrun_q;
  logic [CNT_W-1:0] trig_q;
  logic [7:0] rd_q;
  logic irq_q;

  logic dlab, is_data;
  logic [CNT_W-1:0] fifo_count, fifo_max, count_next;
  logic [DATA_W-1:0] fifo_rdata;
  logic pop, push_ok, push_bad, clr;
  logic [7:0] iir_v, lsr_v, msr_v;
  logic irq_set;

  assign dlab     = lcr_q[7];
  assign is_data  = (addr == OFS_DATA) && !dlab;
  assign fifo_max = fifo_en_q ? CNT_W'(DEPTH) : CNT_W'(1);
  assign pop      = rd_en && is_data && (fifo_count != '0);
  assign push_ok  = wr_en && is_data && (fifo_count < fifo_max);
  assign push_bad = wr_en && is_data && !(fifo_count < fifo_max);
  assign clr      = wr_en && (addr == OFS_FCR) && (wr_data[1] | wr_data[2]);
  assign count_next = fifo_count + CNT_W'(push_ok) - CNT_W'(pop);

  loopuart_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
    .clk(clk), .rst(rst), .clr(clr), .push(push_ok), .pop(pop),
    .wdata(wr_data), .rdata(fifo_rdata), .count(fifo_count)
  );

  loopuart_status #(.CNT_W(CNT_W)) i_status (
    .ier(ier_q[3:0]), .mcr(mcr_q), .overrun(overrun_q), .count(fifo_count),
    .trig(trig_q), .fmax(fifo_max), .iir(iir_v), .lsr(lsr_v), .msr(msr_v)
  );

  always_comb begin
    irq_set = 1'b0;
    if (push_ok && ier_q[EN_RXDATA] && count_next == trig_q) irq_set = 1'b1;
    if (push_bad && ier_q[EN_LINE]) irq_set = 1'b1;
    if (pop && !push_ok && fifo_count == CNT_W'(1) && ier_q[EN_TXEMPTY]) irq_set = 1'b1;
    if (wr_en && addr == OFS_IER && !dlab && wr_data[EN_TXEMPTY] && fifo_count == '0)
      irq_set = 1'b1;
    if (wr_en && addr == OFS_MCR && ier_q[EN_MODEM] && (wr_data[3] | wr_data[1] | wr_data[0]))
      irq_set = 1'b1;
  end

  // register writes
  always_ff @(posedge clk) begin
    if (rst) begin
      ier_q <= '0; lcr_q <= '0; mcr_q <= '0; scr_q <= '0;
      div_q <= '0; fifo_en_q <= 1'b1; overrun_q <= 1'b0;
      trig_q <= CNT_W'(1);
    end else begin
      if (push_ok)  overrun_q <= 1'b0;
      if (push_bad) overrun_q <= 1'b1;
      if (wr_en) begin
        case (addr)
          OFS_DATA: if (dlab) div_q[7:0] <= div_q[7:0] | wr_data;
          OFS_IER: begin
            if (dlab) div_q[15:8] <= div_q[15:8] | wr_data;
            else      ier_q <= wr_data;
          end
          OFS_FCR: begin
            fifo_en_q <= wr_data[0];
            trig_q <= wr_data[0] ? CNT_W'(trig_decode(wr_data[7:6])) : CNT_W'(1);
          end
          OFS_LCR: begin
            lcr_q <= wr_data;
            if (wr_data[7]) div_q <= '0;
          end
          OFS_MCR: mcr_q <= wr_data;
          OFS_SCR: scr_q <= wr_data;
          default: ;
        endcase
      end
    end
  end

  // registered read data and interrupt pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_set;
      if (rd_en) begin
        case (addr)
          OFS_DATA: rd_q <= dlab ? div_q[7:0] : ((fifo_count != '0) ? fifo_rdata : 8'h00);
          OFS_IER:  rd_q <= dlab ? div_q[15:8] : {4'h0, ier_q[3:0]};
          OFS_FCR:  rd_q <= iir_v;
          OFS_LCR:  rd_q <= lcr_q;
          OFS_MCR:  rd_q <= mcr_q;
          OFS_LSR:  rd_q <= lsr_v;
          OFS_MSR:  rd_q <= msr_v;
          default:  rd_q <= scr_q;
        endcase
      end
    end
  end

  assign rd_data = rd_q;
  assign irq = irq_q;
endmodule

// File: rtl/loopuart_regs_chk.sv
module loopuart_regs_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       addr,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic             rd_en,
  input logic [7:0]       rd_data,
  input logic             dlab,
  input logic             overrun_q,
  input logic [CNT_W-1:0] fifo_count,
  input logic [CNT_W-1:0] fifo_max
);
  p_count_bound_r3: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(DEPTH));

  p_overflow_flag_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd0 && !dlab && fifo_count >= fifo_max) |=> overrun_q);

  p_fcr_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 3'd2 && (wr_data[1] | wr_data[2])) |=> fifo_count == '0);

  p_ier_low_nibble_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd1 && !dlab) |=> rd_data[7:4] == 4'h0);

  p_iir_fixed_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 3'd2) |=> rd_data[7:6] == 2'b11);

  p_ignored_writes_r12: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && (addr == 3'd5 || addr == 3'd6)) |=>
      ($stable(fifo_count) && $stable(overrun_q)));

  p_rd_hold_r14: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind loopuart_regs loopuart_regs_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .dlab(dlab), .overrun_q(overrun_q),
  .fifo_count(fifo_count), .fifo_max(fifo_max)
);

// File: tb/test_loopuart_regs.sv
module test_loopuart_regs;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  loopuart_regs i_loopuart_regs (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
  );

  // reference model state
  logic [7:0] m_mem [16];
  int m_head, m_tail, m_cnt, m_trig;
  bit m_ovr, m_fen;
  logic [7:0] m_ier, m_lcr, m_mcr, m_scr, e_rd;
  logic [15:0] m_div;
  bit e_irq;

  function automatic logic [7:0] m_iir();
    if (m_ier[2] && m_ovr) return 8'hC6;
    if (m_ier[0] && m_cnt >= m_trig) return 8'hC4;
    if (m_ier[1] && m_cnt == 0) return 8'hC2;
    if (m_ier[3] && (m_mcr[1] || m_mcr[0])) return 8'hC0;
    return 8'hC1;
  endfunction

  function automatic logic [7:0] m_lsr();
    logic [7:0] v = 8'h00;
    if (m_cnt != 0) v[0] = 1'b1;
    if (m_ovr) v[1] = 1'b1;
    if (m_cnt == 0) v = v | 8'h60;
    return v;
  endfunction

  function automatic logic [7:0] m_msr();
    int mx = m_fen ? 16 : 1;
    if (m_mcr[5] && m_cnt >= mx) return 8'hA2;
    return 8'hB3;
  endfunction

  function automatic int lvl(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 4 : (c == 2) ? 8 : 14;
  endfunction

  task automatic m_reset();
    m_head = 0; m_tail = 0; m_cnt = 0; m_trig = 1; m_ovr = 0; m_fen = 1;
    m_ier = 0; m_lcr = 0; m_mcr = 0; m_scr = 0; m_div = 0; e_rd = 0; e_irq = 0;
  endtask

  task automatic m_apply(input bit rd, input bit wr, input logic [2:0] a, input logic [7:0] d);
    bit dl = m_lcr[7];
    int mx = m_fen ? 16 : 1;
    bit pop, pok, pbad;
    int nc;
    e_irq = 0;
    pop  = rd && a == 0 && !dl && m_cnt != 0;
    pok  = wr && a == 0 && !dl && m_cnt < mx;
    pbad = wr && a == 0 && !dl && m_cnt >= mx;
    nc = m_cnt + int'(pok) - int'(pop);
    if (rd) begin
      case (a)
        0: e_rd = dl ? m_div[7:0] : (m_cnt != 0 ? m_mem[m_tail] : 8'h00);
        1: e_rd = dl ? m_div[15:8] : {4'h0, m_ier[3:0]};
        2: e_rd = m_iir();
        3: e_rd = m_lcr;
        4: e_rd = m_mcr;
        5: e_rd = m_lsr();
        6: e_rd = m_msr();
        default: e_rd = m_scr;
      endcase
    end
    if (pok && m_ier[0] && nc == m_trig) e_irq = 1;
    if (pbad && m_ier[2]) e_irq = 1;
    if (pop && !pok && m_cnt == 1 && m_ier[1]) e_irq = 1;
    if (wr && a == 1 && !dl && d[1] && m_cnt == 0) e_irq = 1;
    if (wr && a == 4 && m_ier[3] && (d[3] || d[1] || d[0])) e_irq = 1;
    if (pop) m_tail = (m_tail + 1) % 16;
    if (pok) begin m_mem[m_head] = d; m_head = (m_head + 1) % 16; m_ovr = 0; end
    if (pbad) m_ovr = 1;
    m_cnt = nc;
    if (wr) begin
      case (a)
        0: if (dl) m_div[7:0] = m_div[7:0] | d;
        1: if (dl) m_div[15:8] = m_div[15:8] | d; else m_ier = d;
        2: begin
          if (d[1] || d[2]) begin m_head = 0; m_tail = 0; m_cnt = 0; end
          m_fen = d[0];
          m_trig = d[0] ? lvl(d[7:6]) : 1;
        end
        3: begin m_lcr = d; if (d[7]) m_div = 0; end
        4: m_mcr = d;
        7: m_scr = d;
        default: ;
      endcase
    end
  endtask

  // one access: drive at falling edge, sample at the next falling edge
  task automatic step(input bit rd, input bit wr, input logic [2:0] a,
                      input logic [7:0] d, input string tag);
    rd_en = rd; wr_en = wr; addr = a; wr_data = d;
    m_apply(rd, wr, a, d);
    @(negedge clk);
    rd_en = 0; wr_en = 0;
    checks++;
    if (rd_data !== e_rd) begin
      errors++;
      $display("FAIL %s rd_data off=%0d actual=%h expected=%h", tag, a, rd_data, e_rd);
    end
    checks++;
    if (irq !== e_irq) begin
      errors++;
      $display("FAIL %s/R14 irq off=%0d actual=%b expected=%b", tag, a, irq, e_irq);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
    step(0, 1, a, d, tag);
  endtask

  task automatic rd(input logic [2:0] a, input string tag);
    step(1, 0, a, 8'h00, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R14 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(2, "R1"); rd(5, "R1"); rd(6, "R1"); rd(3, "R1"); rd(0, "R1");
    // R12 scratch, readback, ignored writes
    wr(7, 8'h5A, "R12"); rd(7, "R12");
    wr(5, 8'hFF, "R12"); rd(5, "R12"); wr(6, 8'h00, "R12"); rd(6, "R12");
    wr(4, 8'h02, "R12"); rd(4, "R12"); wr(4, 8'h00, "R12");
    // R6 and R10 IER readback and transmit-empty pulse
    wr(1, 8'hFF, "R6"); rd(1, "R6"); wr(1, 8'h00, "R10");
    // R2 divisor
    wr(3, 8'h80, "R2"); wr(0, 8'h12, "R2"); wr(0, 8'h21, "R2"); wr(1, 8'h40, "R2");
    rd(0, "R2"); rd(1, "R2"); wr(3, 8'h83, "R2"); rd(0, "R2"); rd(3, "R2");
    wr(3, 8'h03, "R2");
    // R3 R4 R7 R8 R10 fill past capacity with trigger 8
    wr(1, 8'h07, "R10"); wr(2, 8'h81, "R5");
    for (int i = 0; i < 17; i++) wr(0, 8'(8'h30 + i), "R3");
    rd(2, "R7"); rd(5, "R8");
    for (int i = 0; i < 16; i++) rd(0, "R4");
    rd(0, "R4"); rd(5, "R8"); rd(2, "R7");
    // R13 simultaneous push and pop, partly filled and full
    wr(0, 8'hA1, "R13"); wr(0, 8'hA2, "R13");
    step(1, 1, 0, 8'hA3, "R13"); rd(0, "R13"); rd(0, "R13");
    for (int i = 0; i < 16; i++) wr(0, 8'(i), "R13");
    step(1, 1, 0, 8'hEE, "R13"); rd(5, "R13");
    // R5 clear and disabled FIFO
    wr(2, 8'h07, "R5"); rd(5, "R5");
    wr(2, 8'h00, "R5"); wr(0, 8'h11, "R5"); wr(0, 8'h22, "R5"); rd(5, "R5"); rd(0, "R5");
    // R9 and R11 modem bits
    wr(2, 8'h03, "R9"); wr(1, 8'h08, "R11"); wr(4, 8'h01, "R11"); rd(2, "R7");
    wr(4, 8'h20, "R9"); rd(6, "R9");
    for (int i = 0; i < 16; i++) wr(0, 8'(i), "R9");
    rd(6, "R9"); wr(4, 8'h00, "R9"); rd(6, "R9");
    // R14 hold with idle cycles
    rd(7, "R14"); step(0, 0, 0, 8'h00, "R14"); step(0, 0, 0, 8'h00, "R14");
    // random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6000; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      bit r, w;
      a = ($urandom_range(0, 2) == 0) ? 3'd0 : 3'($urandom_range(0, 7));
      d = 8'($urandom);
      if (a == 3) d[7] = ($urandom_range(0, 3) == 0);
      if (a == 2 && $urandom_range(0, 3) != 0) d[2:1] = 2'b00;
      r = $urandom_range(0, 1) == 1;
      w = $urandom_range(0, 1) == 1;
      step(r, w, a, d, "R13/R10/R11");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule